// File: doc/BRIEF.md
# I/O Port Range Decoder

The block steers I/O-space transactions to a destination in a multi-node system. Software programs four window pairs. Each pair has a base word and a limit word. The base word holds the lower bound, the read and write enables, and two legacy-override flags. The limit word holds the upper bound and the destination node and link. A lookup presents a 25-bit I/O address and a direction flag. One cycle later the block reports whether a window claimed the access, the winning window number, and the node and link the access should be sent to.

Window bounds are compared on address bits 24:12, so the granularity is 4 KB and both bounds are inclusive. Two flags can override the plain bound comparison. The first is a display flag. With it set, the legacy display port windows below 64 KB are claimed no matter what the bounds say. The second is an alias-suppression flag. With it set, addresses below 64 KB whose bits 9:8 are non-zero are kept out of the bound comparison. When several windows claim one address, the lowest-numbered window wins.

Configuration words are addressed by a 3-bit word index. Index bits 2:1 select the pair, and index bit 0 selects base (0) or limit (1). A combinational read port returns any word. The block has no state machine: configuration is a plain register file, and each lookup takes exactly one registered stage.

Top module: `pio_range_decoder`

## Requirements
- R1: After reset, all eight configuration words read as zero, `rs_valid` is low, and a lookup at address 0 misses.
- R2: Reserved bits read as zero and ignore writes. The kept bits are 0x01FFF033 for a base word and 0x01FFF037 for a limit word. In a base word, bit 0 is the read enable, bit 1 the write enable, bit 4 the display flag, bit 5 the alias flag, and bits 24:12 the lower bound. In a limit word, bits 2:0 are the node, bits 5:4 the link, and bits 24:12 the upper bound.
- R3: A limit write whose link field (bits 5:4) is 11 leaves the stored link unchanged while all other kept bits update.
- R4: A pair matches by range when base[24:12] ≤ addr[24:12] ≤ limit[24:12], with both bounds inclusive. The result appears with `rs_valid` high on the cycle after `lk_valid` is sampled, and `rs_valid` is low otherwise.
- R5: A read (`lk_write`=0) needs base bit 0 set, and a write (`lk_write`=1) needs base bit 1 set. This applies to range matches and display matches alike.
- R6: On a hit, `rs_node` is limit bits 2:0 and `rs_link` is limit bits 5:4 of the winning pair, and `rs_idx` is that pair's number.
- R7: When several pairs match, the lowest-numbered pair wins.
- R8: On a miss, `rs_hit`, `rs_node`, `rs_link` and `rs_idx` are all zero.
- R9: With the display flag set, an address below 0x10000 whose bits 9:0 lie in 0x3B0..0x3BB or 0x3C0..0x3DF matches regardless of the bounds, provided the direction is enabled. Addresses at or above 0x10000 never match this way.
- R10: With the alias flag set, an address below 0x10000 with bits 9:8 not equal to 00 cannot match by range. Addresses at or above 0x10000 are not affected. A display match is not blocked by the alias flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | 3 | Word index for the write: bits 2:1 select the pair, bit 0 selects limit |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_idx | input | 3 | Word index for the read port |
| cfg_rd_data | output | 32 | Selected configuration word, with reserved bits zero |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 25 | I/O address to decode |
| lk_write | input | 1 | 1 for a write access, 0 for a read access |
| rs_valid | output | 1 | Result valid, one cycle after the request |
| rs_hit | output | 1 | Some pair claimed the address |
| rs_node | output | 3 | Destination node |
| rs_link | output | 2 | Destination link |
| rs_idx | output | 2 | Winning pair number |

## Verification
The bench probes both inclusive bound edges and the first address past a limit. A comparison that is off by one would claim 0xE000, or drop 0xDFFF or 0x20FFF. It probes the display windows at 0x3B4, 0x3BB+1, 0x3C0, 0x3DF and 0x3E0, and repeats the probe above 64 KB and with the enables cleared. A decoder that skipped the below-64 KB test or the direction enable would then report a hit where a miss is expected. Alias suppression is checked at 0xE100, where every range pair must back off, and at 0x20100, where the same offset must still match. Overlapping windows and a link-code-11 write expose a wrong priority order and a reserved code stored blindly.

// File: rtl/pio_dec_pkg.sv
package pio_dec_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 25;
    localparam int NODE_W    = 3;
    localparam int LINK_W    = 2;
    localparam int BND_LO    = 12;
    localparam int BND_HI    = 24;
    localparam int SMALL_TOP = 16;          // addresses below 2**16 are legacy space
    localparam int BIT_RDEN  = 0;
    localparam int BIT_WREN  = 1;
    localparam int BIT_DISP  = 4;
    localparam int BIT_ALIAS = 5;
    localparam int LINK_LO   = 4;
    localparam logic [WORD_W-1:0] BASE_KEEP  = 32'h01FF_F033;
    localparam logic [WORD_W-1:0] LIMIT_KEEP = 32'h01FF_F037;
    localparam logic [LINK_W-1:0] LINK_RSVD  = 2'b11;
    localparam logic [9:0] DISP_A_LO = 10'h3B0;
    localparam logic [9:0] DISP_A_HI = 10'h3BB;
    localparam logic [9:0] DISP_B_LO = 10'h3C0;
    localparam logic [9:0] DISP_B_HI = 10'h3DF;
endpackage

// File: rtl/pio_range_regs.sv
module pio_range_regs
    import pio_dec_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    localparam int PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
    localparam int WIDX_W = PAIR_W + 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [WIDX_W-1:0]                  wr_idx,
    input  logic [WORD_W-1:0]                  wr_data,
    input  logic [WIDX_W-1:0]                  rd_idx,
    output logic [WORD_W-1:0]                  rd_data,
    output logic [NUM_PAIRS-1:0][WORD_W-1:0]   base_q,
    output logic [NUM_PAIRS-1:0][WORD_W-1:0]   limit_q
);
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic sel;
        logic [WORD_W-1:0] lim_next;
        assign sel = wr_en && (32'(wr_idx[WIDX_W-1:1]) == p);

        always_comb begin
            lim_next = wr_data & LIMIT_KEEP;
            if (wr_data[LINK_LO +: LINK_W] == LINK_RSVD)
                lim_next[LINK_LO +: LINK_W] = limit_q[p][LINK_LO +: LINK_W];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[p]  <= '0;
                limit_q[p] <= '0;
            end else if (sel) begin
                if (wr_idx[0]) limit_q[p] <= lim_next;
                else           base_q[p]  <= wr_data & BASE_KEEP;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (32'(rd_idx[WIDX_W-1:1]) == p)
                rd_data = rd_idx[0] ? limit_q[p] : base_q[p];
        end
    end
endmodule

// File: rtl/pio_range_match.sv
module pio_range_match
    import pio_dec_pkg::*;
(
    input  logic [WORD_W-1:0] base_w,
    input  logic [WORD_W-1:0] limit_w,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output logic              match
);
    logic       dir_ok;
    logic       small_space;
    logic [9:0] low10;
    logic       in_disp;
    logic       in_bounds;
    logic       aliased;
    logic       unused_bits;

    assign unused_bits = ^{base_w[31:25], base_w[11:6], base_w[3:2],
                           limit_w[31:25], limit_w[11:0]};

    assign dir_ok      = is_write ? base_w[BIT_WREN] : base_w[BIT_RDEN];
    assign small_space = (addr[ADDR_W-1:SMALL_TOP] == '0);
    assign low10       = addr[9:0];
    assign in_disp     = small_space &&
                         (((low10 >= DISP_A_LO) && (low10 <= DISP_A_HI)) ||
                          ((low10 >= DISP_B_LO) && (low10 <= DISP_B_HI)));
    assign in_bounds   = (addr[BND_HI:BND_LO] >= base_w[BND_HI:BND_LO]) &&
                         (addr[BND_HI:BND_LO] <= limit_w[BND_HI:BND_LO]);
    assign aliased     = base_w[BIT_ALIAS] && small_space && (addr[9:8] != 2'b00);

    assign match = dir_ok && ((base_w[BIT_DISP] && in_disp) || (in_bounds && !aliased));
endmodule

// File: rtl/pio_range_pick.sv
module pio_range_pick #(
    parameter int NUM_PAIRS = 4,
    localparam int PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic [NUM_PAIRS-1:0] hits,
    output logic                 any,
    output logic [PAIR_W-1:0]    win
);
    always_comb begin
        any = |hits;
        win = '0;
        for (int p = NUM_PAIRS - 1; p >= 0; p--) begin
            if (hits[p]) win = PAIR_W'(p);
        end
    end
endmodule

// File: rtl/pio_range_decoder.sv
module pio_range_decoder
    import pio_dec_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    localparam int PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
    localparam int WIDX_W = PAIR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [WIDX_W-1:0] cfg_wr_idx,
    input  logic [31:0]       cfg_wr_data,
    input  logic [WIDX_W-1:0] cfg_rd_idx,
    output logic [31:0]       cfg_rd_data,
    input  logic              lk_valid,
    input  logic [24:0]       lk_addr,
    input  logic              lk_write,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic [2:0]        rs_node,
    output logic [1:0]        rs_link,
    output logic [PAIR_W-1:0] rs_idx
);
    logic [NUM_PAIRS-1:0][WORD_W-1:0] base_q;
    logic [NUM_PAIRS-1:0][WORD_W-1:0] limit_q;
    logic [NUM_PAIRS-1:0]             pair_hit;
    logic                             any_hit;
    logic [PAIR_W-1:0]                win_idx;
    logic [WORD_W-1:0]                win_limit;

    pio_range_regs #(.NUM_PAIRS(NUM_PAIRS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_idx  (cfg_wr_idx),
        .wr_data (cfg_wr_data),
        .rd_idx  (cfg_rd_idx),
        .rd_data (cfg_rd_data),
        .base_q  (base_q),
        .limit_q (limit_q)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_match
        pio_range_match u_match (
            .base_w   (base_q[p]),
            .limit_w  (limit_q[p]),
            .addr     (lk_addr),
            .is_write (lk_write),
            .match    (pair_hit[p])
        );
    end

    pio_range_pick #(.NUM_PAIRS(NUM_PAIRS)) u_pick (
        .hits (pair_hit),
        .any  (any_hit),
        .win  (win_idx)
    );

    assign win_limit = limit_q[win_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_node  <= '0;
            rs_link  <= '0;
            rs_idx   <= '0;
        end else begin
            rs_valid <= lk_valid;
            rs_hit   <= lk_valid && any_hit;
            if (lk_valid && any_hit) begin
                rs_node <= win_limit[NODE_W-1:0];
                rs_link <= win_limit[LINK_LO +: LINK_W];
                rs_idx  <= win_idx;
            end else begin
                rs_node <= '0;
                rs_link <= '0;
                rs_idx  <= '0;
            end
        end
    end
endmodule

// File: rtl/pio_range_decoder_chk.sv
module pio_range_decoder_chk
    import pio_dec_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic [2:0]  cfg_rd_idx,
    input logic [31:0] cfg_rd_data,
    input logic        rs_valid,
    input logic        rs_hit,
    input logic [2:0]  rs_node,
    input logic [1:0]  rs_link,
    input logic [1:0]  rs_idx
);
    logic [31:0] keep_mask;
    assign keep_mask = cfg_rd_idx[0] ? LIMIT_KEEP : BASE_KEEP;

    assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid);
    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit) |-> (rs_node == 3'd0 && rs_link == 2'd0 && rs_idx == 2'd0));
    assert_hit_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit |-> rs_valid);
    assert_no_rsvd_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit |-> (rs_link != LINK_RSVD));
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data & ~keep_mask) == 32'd0);
endmodule

bind pio_range_decoder pio_range_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .cfg_rd_idx  (cfg_rd_idx),
    .cfg_rd_data (cfg_rd_data),
    .rs_valid    (rs_valid),
    .rs_hit      (rs_hit),
    .rs_node     (rs_node),
    .rs_link     (rs_link),
    .rs_idx      (rs_idx)
);

// File: tb/pio_range_decoder_tb.sv
module pio_range_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_idx = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [2:0]  cfg_rd_idx = '0;
    logic [31:0] cfg_rd_data;
    logic        lk_valid = 1'b0;
    logic [24:0] lk_addr = '0;
    logic        lk_write = 1'b0;
    logic        rs_valid, rs_hit;
    logic [2:0]  rs_node;
    logic [1:0]  rs_link, rs_idx;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic       hit;
        logic [2:0] node;
        logic [1:0] link;
        logic [1:0] idx;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t cur;

    always #2.5 clk = ~clk;

    pio_range_decoder dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_write(lk_write),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_node(rs_node),
        .rs_link(rs_link), .rs_idx(rs_idx)
    );

    task automatic cfg_write(input logic [2:0] idx, input logic [31:0] data);
        cfg_wr_en   = 1'b1;
        cfg_wr_idx  = idx;
        cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic cfg_check(input logic [2:0] idx, input logic [31:0] expv, input string tag);
        cfg_rd_idx = idx;
        #1;
        checks++;
        if (cfg_rd_data !== expv) begin
            fails++;
            $display("FAIL %s word %0d: actual %h expected %h", tag, idx, cfg_rd_data, expv);
        end
    endtask

    task automatic lookup(input logic [24:0] a, input logic wr, input logic h,
                          input logic [2:0] n, input logic [1:0] l, input logic [1:0] i,
                          input string tag);
        exp_t e;
        e.hit = h; e.node = n; e.link = l; e.idx = i; e.tag = tag;
        exp_q.push_back(e);
        lk_valid = 1'b1;
        lk_addr  = a;
        lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // monitor: pops the oldest expectation for each result
    always @(negedge clk) begin
        if (rst_n && rs_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R4 unexpected result: actual hit=%0b expected none", rs_hit);
            end else begin
                cur = exp_q.pop_front();
                if (rs_hit !== cur.hit || rs_node !== cur.node ||
                    rs_link !== cur.link || rs_idx !== cur.idx) begin
                    fails++;
                    $display("FAIL %s: actual hit=%0b node=%0d link=%0d idx=%0d expected hit=%0b node=%0d link=%0d idx=%0d",
                             cur.tag, rs_hit, rs_node, rs_link, rs_idx,
                             cur.hit, cur.node, cur.link, cur.idx);
                end
            end
        end
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        checks++;
        if (rs_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 rs_valid after reset: actual %b expected 0", rs_valid);
        end
        for (int w = 0; w < 8; w++) cfg_check(3'(w), 32'h0, "R1");
        lookup(25'h0, 1'b0, 1'b0, 3'd0, 2'd0, 2'd0, "R1 lookup after reset");

        // program windows
        cfg_write(3'd0, 32'h0000_D003);  // pair0 base D, rd+wr
        cfg_write(3'd1, 32'h0000_D011);  // pair0 limit D, node1 link1
        cfg_write(3'd2, 32'h0001_0013);  // pair1 base 0x10, disp, rd+wr
        cfg_write(3'd3, 32'h0001_F022);  // pair1 limit 0x1F, node2 link2
        cfg_write(3'd4, 32'h0000_0021);  // pair2 base 0, alias, rd only
        cfg_write(3'd5, 32'h0000_F003);  // pair2 limit 0xF, node3 link0
        cfg_write(3'd6, 32'h0000_D021);  // pair3 base D, alias, rd only
        cfg_write(3'd7, 32'h0002_0015);  // pair3 limit 0x20, node5 link1

        lookup(25'h0D000, 1'b0, 1'b1, 3'd1, 2'd1, 2'd0, "R4 R7 lower bound, overlap");
        lookup(25'h0DFFF, 1'b0, 1'b1, 3'd1, 2'd1, 2'd0, "R4 upper bound");
        lookup(25'h0D000, 1'b1, 1'b1, 3'd1, 2'd1, 2'd0, "R5 write enable");
        lookup(25'h0E000, 1'b1, 1'b0, 3'd0, 2'd0, 2'd0, "R5 R8 write to read-only");
        lookup(25'h0E000, 1'b0, 1'b1, 3'd3, 2'd0, 2'd2, "R6 R7 pair2 over pair3");
        lookup(25'h0E100, 1'b0, 1'b0, 3'd0, 2'd0, 2'd0, "R10 alias blocked");
        lookup(25'h20100, 1'b0, 1'b1, 3'd5, 2'd1, 2'd3, "R10 alias not above 64K");
        lookup(25'h20FFF, 1'b0, 1'b1, 3'd5, 2'd1, 2'd3, "R4 pair3 upper bound");
        lookup(25'h003B4, 1'b0, 1'b1, 3'd2, 2'd2, 2'd1, "R9 display window A");
        lookup(25'h003C0, 1'b1, 1'b1, 3'd2, 2'd2, 2'd1, "R9 display window B write");
        lookup(25'h003DF, 1'b0, 1'b1, 3'd2, 2'd2, 2'd1, "R9 display window B top");
        lookup(25'h003BC, 1'b0, 1'b0, 3'd0, 2'd0, 2'd0, "R9 past window A");
        lookup(25'h003E0, 1'b0, 1'b0, 3'd0, 2'd0, 2'd0, "R9 past window B");
        lookup(25'h213B0, 1'b0, 1'b0, 3'd0, 2'd0, 2'd0, "R9 not above 64K");
        @(negedge clk);

        // R9/R5: display match needs the direction enable
        cfg_write(3'd2, 32'h0001_0010);
        lookup(25'h003B4, 1'b0, 1'b0, 3'd0, 2'd0, 2'd0, "R9 R5 display without enable");

        // R3: reserved link code keeps old link
        cfg_write(3'd1, 32'h0000_E036);
        cfg_check(3'd1, 32'h0000_E016, "R3");
        lookup(25'h0E000, 1'b0, 1'b1, 3'd6, 2'd1, 2'd0, "R3 R6 updated limit");

        // R2: reserved bits
        cfg_write(3'd4, 32'hFFFF_FFFF);
        cfg_check(3'd4, 32'h01FF_F033, "R2 base");
        cfg_write(3'd5, 32'hFFFF_FFFF);
        cfg_check(3'd5, 32'h01FF_F007, "R2 R3 limit");

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R4 missing results: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule